// File: doc/BRIEF.md
# Column-Major Lookup Matrix-Vector Engine

This block forms the product y = M·x for a small matrix of unsigned integers and a vector of the same element width, with no multiplier. Every possible product of two operands is held in a lookup memory arranged as rows. One row holds all products for a single vector value. The engine opens one row and then reads products out of it, with the matrix elements acting as column addresses.

The engine works through the matrix one column at a time. At the start of a column it opens the lookup row chosen by that column's vector element and waits out the activation latency. It then reads one product per cycle, one for each matrix row, and adds each product into that row's accumulator. The row is opened only once per vector element, so one full product costs exactly as many activations as the vector has elements. A start pulse copies the matrix and vector into local registers and clears the accumulators. A one-cycle done pulse marks the end of the product. An activation counter reports how many rows were opened during the current run.

Top module: `lut_mv_top`

## Requirements
- R1: After reset, done_o is 0, act_cnt_o is 0 and every result lane is 0.
- R2: When done_o pulses, result lane r (bits [r*16 +: 16] of result_o) equals the sum over c of mat_i element (r,c) times vec_i element c. Element (r,c) sits at bits [(r*COLS+c)*4 +: 4] of mat_i, element c sits at bits [c*4 +: 4] of vec_i, and all operands are unsigned.
- R3: When done_o pulses, act_cnt_o equals COLS, and act_cnt_o never exceeds COLS.
- R4: No row is re-opened while the reads for one column are in progress. k cycles after the start edge (k at least 1), act_cnt_o equals min(COLS, floor((k-1)/(ACT_LAT+ROWS))+1).
- R5: done_o rises exactly COLS*(ACT_LAT+ROWS) clock edges after the edge that accepted start_i.
- R6: done_o is high for exactly one cycle per run.
- R7: A start_i pulse that arrives while the engine is busy is ignored. Changes to mat_i and vec_i during a run have no effect. The run's results, its activation count and its latency all stay unchanged.
- R8: An accepted start clears the accumulators and the activation counter, so a run's result does not depend on earlier runs.
- R9: All-zero operands give all-zero results. All-maximum operands (15) give 15*15*COLS in every lane without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mat_i | input | ROWS*COLS*4 | Flattened matrix, row-major element order |
| vec_i | input | COLS*4 | Flattened vector |
| result_o | output | ROWS*16 | Accumulated result lanes |
| done_o | output | 1 | One-cycle completion pulse |
| act_cnt_o | output | 32 | Row activations since the last accepted start |

## Verification
The checker tests on every cycle that done is a single pulse and that the activation count never goes past the column count. It also checks that the count equals the column count when done fires, that no activation happens straight after a read inside a column, and that a start while busy does not restart the engine. Only the bench scenarios can show that the products are correct, that the latency is exact, and that inputs changed in the middle of a run are ignored. The same holds for the accumulator clear between runs and the zero and all-maximum extremes.

// File: rtl/lut_mv_pkg.sv
package lut_mv_pkg;
    localparam int OPW     = 4;
    localparam int PRODW   = 2 * OPW;
    localparam int LUT_DIM = 1 << OPW;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_READ,
        ST_FIN
    } state_e;

    // Precomputed product for table row (vector value) r and column (matrix value) c
    function automatic logic [PRODW-1:0] prod_entry(input int r, input int c);
        return PRODW'(r * c);
    endfunction
endpackage

// File: rtl/lut_table.sv
module lut_table
    import lut_mv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             open_i,
    input  logic [OPW-1:0]   row_i,
    input  logic [OPW-1:0]   col_i,
    output logic [PRODW-1:0] entry_o
);
    logic [PRODW-1:0] rom [LUT_DIM][LUT_DIM];

    for (genvar r = 0; r < LUT_DIM; r++) begin : g_row
        for (genvar c = 0; c < LUT_DIM; c++) begin : g_col
            assign rom[r][c] = prod_entry(r, c);
        end
    end

    logic [OPW-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (open_i) row_d = row_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) row_q <= '0;
        else         row_q <= row_d;
    end

    assign entry_o = rom[row_q][col_i];
endmodule

// File: rtl/lut_ctrl.sv
module lut_ctrl
    import lut_mv_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int COLS    = 8,
    parameter int ACT_LAT = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    output logic          clr_o,
    output logic          open_o,
    output logic          rd_o,
    output logic [$clog2(ROWS > 1 ? ROWS : 2)-1:0] row_o,
    output logic [$clog2(COLS > 1 ? COLS : 2)-1:0] col_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [31:0]   act_cnt_o
);
    localparam int RW = $clog2(ROWS > 1 ? ROWS : 2);
    localparam int CW = $clog2(COLS > 1 ? COLS : 2);
    localparam int WW = $clog2(ACT_LAT > 1 ? ACT_LAT : 2);

    typedef struct packed {
        state_e        st;
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic [WW-1:0] wt;
        logic [31:0]   act;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        clr_o  = 1'b0;
        open_o = 1'b0;
        rd_o   = 1'b0;
        done_o = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    clr_o   = 1'b1;
                    s_d.st  = ST_OPEN;
                    s_d.col = '0;
                    s_d.row = '0;
                    s_d.wt  = '0;
                    s_d.act = '0;
                end
            end
            ST_OPEN: begin
                if (s_q.wt == '0) begin
                    open_o  = 1'b1;
                    s_d.act = s_q.act + 32'd1;
                end
                if (s_q.wt == WW'(ACT_LAT - 1)) begin
                    s_d.st  = ST_READ;
                    s_d.row = '0;
                    s_d.wt  = '0;
                end else begin
                    s_d.wt = s_q.wt + WW'(1);
                end
            end
            ST_READ: begin
                rd_o = 1'b1;
                if (s_q.row == RW'(ROWS - 1)) begin
                    if (s_q.col == CW'(COLS - 1)) begin
                        s_d.st = ST_FIN;
                    end else begin
                        s_d.st  = ST_OPEN;
                        s_d.col = s_q.col + CW'(1);
                        s_d.wt  = '0;
                    end
                end else begin
                    s_d.row = s_q.row + RW'(1);
                end
            end
            ST_FIN: begin
                done_o = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_IDLE, col: '0, row: '0, wt: '0, act: '0};
        else         s_q <= s_d;
    end

    assign row_o     = s_q.row;
    assign col_o     = s_q.col;
    assign busy_o    = (s_q.st != ST_IDLE);
    assign act_cnt_o = s_q.act;
endmodule

// File: rtl/lut_acc_bank.sv
module lut_acc_bank
    import lut_mv_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int ACCW = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   clr_i,
    input  logic                   add_i,
    input  logic [$clog2(ROWS > 1 ? ROWS : 2)-1:0] idx_i,
    input  logic [PRODW-1:0]       addend_i,
    output logic [ROWS*ACCW-1:0]   acc_o
);
    logic [ACCW-1:0] acc_d [ROWS];
    logic [ACCW-1:0] acc_q [ROWS];

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            for (int i = 0; i < ROWS; i++) acc_d[i] = '0;
        end else if (add_i) begin
            acc_d[idx_i] = acc_q[idx_i] + ACCW'(addend_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < ROWS; i++) acc_q[i] <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_out
        assign acc_o[g*ACCW +: ACCW] = acc_q[g];
    end
endmodule

// File: rtl/lut_mv_top.sv
module lut_mv_top
    import lut_mv_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int COLS    = 8,
    parameter int ACT_LAT = 3,
    parameter int ACCW    = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic [ROWS*COLS*OPW-1:0] mat_i,
    input  logic [COLS*OPW-1:0]      vec_i,
    output logic [ROWS*ACCW-1:0]     result_o,
    output logic                     done_o,
    output logic [31:0]              act_cnt_o
);
    localparam int RW = $clog2(ROWS > 1 ? ROWS : 2);
    localparam int CW = $clog2(COLS > 1 ? COLS : 2);

    logic          clr_w, open_w, rd_w, busy_w;
    logic [RW-1:0] row_w;
    logic [CW-1:0] col_w;
    logic [PRODW-1:0] entry_w;

    logic [ROWS*COLS*OPW-1:0] mat_d, mat_q;
    logic [COLS*OPW-1:0]      vec_d, vec_q;

    always_comb begin
        mat_d = mat_q;
        vec_d = vec_q;
        if (clr_w) begin
            mat_d = mat_i;
            vec_d = vec_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mat_q <= '0;
            vec_q <= '0;
        end else begin
            mat_q <= mat_d;
            vec_q <= vec_d;
        end
    end

    logic [OPW-1:0] open_row_w, mat_elem_w;
    assign open_row_w = vec_q[col_w*OPW +: OPW];
    assign mat_elem_w = mat_q[(row_w*COLS + col_w)*OPW +: OPW];

    lut_ctrl #(.ROWS(ROWS), .COLS(COLS), .ACT_LAT(ACT_LAT)) i_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .clr_o    (clr_w),
        .open_o   (open_w),
        .rd_o     (rd_w),
        .row_o    (row_w),
        .col_o    (col_w),
        .busy_o   (busy_w),
        .done_o   (done_o),
        .act_cnt_o(act_cnt_o)
    );

    lut_table i_table (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .open_i (open_w),
        .row_i  (open_row_w),
        .col_i  (mat_elem_w),
        .entry_o(entry_w)
    );

    lut_acc_bank #(.ROWS(ROWS), .ACCW(ACCW)) i_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_w),
        .add_i   (rd_w),
        .idx_i   (row_w),
        .addend_i(entry_w),
        .acc_o   (result_o)
    );
endmodule

// File: rtl/lut_mv_chk.sv
module lut_mv_chk #(
    parameter int COLS = 8
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        start_i,
    input logic        busy_i,
    input logic        rd_i,
    input logic        done_i,
    input logic [31:0] act_i
);
    // R6
    a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);
    // R3
    a_r3_done_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> act_i == 32'(COLS));
    // R3
    a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_i <= 32'(COLS));
    // R4
    a_r4_no_reopen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> $stable(act_i));
    // R7
    a_r7_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && start_i && !done_i) |=> busy_i);
    // R8
    a_r8_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i) |=> act_i == 32'd0);
endmodule

bind lut_mv_top lut_mv_chk #(.COLS(COLS)) i_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_i (busy_w),
    .rd_i   (rd_w),
    .done_i (done_o),
    .act_i  (act_cnt_o)
);

// File: tb/test_lut_mv_top.sv
module test_lut_mv_top;
    localparam int ROWS = 8, COLS = 8, ACT_LAT = 3, ACCW = 16;
    localparam int P = ACT_LAT + ROWS;
    localparam int N = COLS * P;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [ROWS*COLS*4-1:0] mat = '0;
    logic [COLS*4-1:0]      vec = '0;
    logic [ROWS*ACCW-1:0]   res;
    logic                   done;
    logic [31:0]            act;
    int total = 0, bad = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    lut_mv_top #(.ROWS(ROWS), .COLS(COLS), .ACT_LAT(ACT_LAT), .ACCW(ACCW)) i_lut_mv_top (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mat_i(mat), .vec_i(vec),
        .result_o(res), .done_o(done), .act_cnt_o(act)
    );

    function automatic logic [ACCW-1:0] exp_lane(input logic [ROWS*COLS*4-1:0] m,
                                                 input logic [COLS*4-1:0] v, input int r);
        int s = 0;
        for (int c = 0; c < COLS; c++) s += int'(m[(r*COLS+c)*4 +: 4]) * int'(v[c*4 +: 4]);
        return ACCW'(s);
    endfunction

    function automatic int exp_act(input int k);
        int a = (k - 1) / P + 1;
        return (a > COLS) ? COLS : a;
    endfunction

    task automatic check(input bit ok, input string req, input string msg, input longint a, input longint e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, msg, a, e);
        end
    endtask

    task automatic run(input logic [ROWS*COLS*4-1:0] m, input logic [COLS*4-1:0] v,
                       input bit poke, input string tag);
        int cnt = 0;
        bit act_ok = 1'b1;
        int bad_act = 0, bad_k = 0;
        @(negedge clk);
        mat = m; vec = v; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && cnt < N + 20) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (act_ok && act != 32'(exp_act(cnt))) begin
                act_ok = 1'b0; bad_act = int'(act); bad_k = cnt;
            end
            if (poke) begin
                mat = ~m; vec = ~v;
                start = (cnt == 5 || cnt == P + 2);
            end
        end
        start = 1'b0;
        check(act_ok, "R4", {tag, " activation trace"}, bad_act, exp_act(bad_k));
        check(cnt == N, poke ? "R7" : "R5", {tag, " latency"}, cnt, N);
        check(act == 32'(COLS), "R3", {tag, " activation count"}, act, COLS);
        for (int r = 0; r < ROWS; r++) begin
            logic [ACCW-1:0] e = exp_lane(m, v, r);
            if (res[r*ACCW +: ACCW] != e) begin
                check(1'b0, poke ? "R7" : "R2", {tag, " result lane"}, res[r*ACCW +: ACCW], e);
            end
        end
        check(1'b1, "R2", {tag, " result lanes"}, 0, 0);
        @(posedge clk);
        @(negedge clk);
        check(!done, "R6", {tag, " done width"}, done, 0);
        mat = '0; vec = '0;
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [ROWS*COLS*4-1:0] m;
        logic [COLS*4-1:0] v;
        int unused;
        unused = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(act == 32'd0, "R1", "act after reset", act, 0);
        check(res == '0, "R1", "result after reset", res[15:0], 0);
        rst_n = 1'b1;
        // R9 extremes
        run('0, '0, 1'b0, "R9 zero");
        run('1, '1, 1'b0, "R9 max");
        check(res[15:0] == 16'(225 * COLS), "R9", "max lane0", res[15:0], 225 * COLS);
        // identity-like matrix
        m = '0;
        for (int i = 0; i < ROWS; i++) m[(i*COLS + (i % COLS))*4 +: 4] = 4'd1;
        for (int c = 0; c < COLS; c++) v[c*4 +: 4] = 4'(c + 3);
        run(m, v, 1'b0, "R2 diag");
        // random cases, back to back: R8 clear between runs
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < ROWS*COLS; i++) m[i*4 +: 4] = 4'($urandom);
            for (int c = 0; c < COLS; c++) v[c*4 +: 4] = 4'($urandom);
            run(m, v, 1'b0, "R8 random");
        end
        // R7 start and operand changes while busy
        for (int i = 0; i < ROWS*COLS; i++) m[i*4 +: 4] = 4'($urandom);
        for (int c = 0; c < COLS; c++) v[c*4 +: 4] = 4'($urandom);
        run(m, v, 1'b1, "R7 busy start");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule